// File: doc/BRIEF.md
# Vectored Interrupt Dispatcher

This block collects up to 64 interrupt vector request lines and a 16-line legacy bus IRQ set, and turns the first new request into one vectored interrupt event for the processor. A line counts as new when it is high in the current cycle and was low in the registered copy of the previous cycle's lines. While the dispatcher is idle, a new request sets the busy flag and raises the request output. It also drives the trap-type output with the vectored-interrupt code and loads a three-word data block. The first word carries a fixed five-bit tag of all ones above the six-bit vector number. The other two words are zero.

Five legacy IRQ lines have fixed vector numbers and are merged (ORed) into the vector lines. The other eleven legacy lines have no effect. While busy, the unit takes no further vectors. Software clears the event by dropping the accepted line: the busy flag then clears, and the request and trap type are withdrawn. A line that is still high at that point has to go low and rise again before it is taken.

Top module: `ivec_dispatch`

## Requirements
- R1: After reset, status is 0, req is 0, trap_type is 0, and data0, data1 and data2 are all 0.
- R2: If a vector line rises while the unit is idle, then at the next clock edge status bit 5 (value 0x20) is set, req is 1 and trap_type equals the vectored-interrupt code (default 0x060). The other status bits stay 0.
- R3: On acceptance, data0 becomes (0x1F << 6) | vector number (for example 0x7C5 for vector 5, 0x7C0 for vector 0 and 0x7FF for vector 63). data1 and data2 become 0.
- R4: When several lines rise in the same cycle, the lowest-numbered line is accepted.
- R5: A line that rises while busy is set is ignored: data0 and the busy flag do not change.
- R6: Dropping the accepted line clears status bit 5, req and trap_type at the next edge. Dropping any other line leaves the unit busy.
- R7: A line that is already high when busy clears is not accepted. It is accepted only after it goes low and then rises again.
- R8: Legacy IRQ 1 raises vector 0x29, IRQ 4 raises 0x2B, IRQ 6 raises 0x27, IRQ 7 raises 0x22 and IRQ 12 raises 0x2A. Dropping the legacy line releases the event.
- R9: Legacy IRQs 0, 2, 3, 5, 8 to 11 and 13 to 15 have no effect: the unit stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_lines | input | 64 | Vector request levels, bit n is vector n |
| legacy_irq | input | 16 | Legacy bus IRQ levels |
| status | output | 8 | Status byte, bit 5 is the busy flag |
| req | output | 1 | Interrupt request to the processor |
| trap_type | output | 9 | Vectored-interrupt code while busy, 0 when idle |
| data0 | output | 16 | Tag and vector number of the accepted event |
| data1 | output | 16 | Second data word, zero on acceptance |
| data2 | output | 16 | Third data word, zero on acceptance |

## Verification
Edge detection, acceptance and release all happen at the same clock edge, so every output is due exactly one edge after the input changes. The bench changes inputs on a falling edge and checks on the next falling edge. That leaves exactly one rising edge in between. A test that a stimulus is ignored samples at that same point, and again one cycle later, so the check covers both the direct effect and a missed edge that might act late.

// File: rtl/ivec_dispatch.sv
module ivec_dispatch #(
  parameter int NVEC = 64,
  parameter int NLEG = 16,
  parameter int DW = 16,
  parameter int TW = 9,
  parameter logic [4:0] TAG = 5'h1F,
  parameter logic [TW-1:0] TRAP_CODE = 9'h060
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] vec_lines,
  input  logic [NLEG-1:0] legacy_irq,
  output logic [7:0]      status,
  output logic            req,
  output logic [TW-1:0]   trap_type,
  output logic [DW-1:0]   data0,
  output logic [DW-1:0]   data1,
  output logic [DW-1:0]   data2
);
  localparam int VW = $clog2(NVEC);
  localparam int BUSY_BIT = 5;

  function automatic int leg_map(input int n);
    case (n)
      1:  leg_map = 'h29;
      4:  leg_map = 'h2B;
      6:  leg_map = 'h27;
      7:  leg_map = 'h22;
      12: leg_map = 'h2A;
      default: leg_map = -1;
    endcase
  endfunction

  logic [NVEC-1:0] leg_vec, eff, prev, rise;
  logic [VW-1:0]   held_idx, win_idx;
  logic            busy, win_ok, drop;

  always_comb begin
    leg_vec = '0;
    for (int n = 0; n < NLEG; n++)
      if (leg_map(n) >= 0 && leg_map(n) < NVEC && legacy_irq[n])
        leg_vec[leg_map(n)] = 1'b1;
  end

  assign eff  = vec_lines | leg_vec;
  assign rise = eff & ~prev;

  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (rise[i]) begin
        win_ok  = 1'b1;
        win_idx = VW'(i);
      end
  end

  assign drop = busy && !eff[held_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= '0;
      busy      <= 1'b0;
      req       <= 1'b0;
      held_idx  <= '0;
      trap_type <= '0;
      data0     <= '0;
      data1     <= '0;
      data2     <= '0;
    end else begin
      prev <= eff;
      if (drop) begin
        busy      <= 1'b0;
        req       <= 1'b0;
        trap_type <= '0;
      end else if (!busy && win_ok) begin
        busy      <= 1'b1;
        req       <= 1'b1;
        held_idx  <= win_idx;
        trap_type <= TRAP_CODE;
        data0     <= DW'({TAG, win_idx});
        data1     <= '0;
        data2     <= '0;
      end
    end
  end

  always_comb begin
    status = '0;
    status[BUSY_BIT] = busy;
  end
endmodule

module ivec_dispatch_chk #(
  parameter int NVEC = 64,
  parameter int NLEG = 16,
  parameter int DW = 16,
  parameter int TW = 9,
  parameter logic [4:0] TAG = 5'h1F,
  parameter logic [TW-1:0] TRAP_CODE = 9'h060
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NVEC-1:0] vec_lines,
  input logic [NLEG-1:0] legacy_irq,
  input logic [7:0]      status,
  input logic            req,
  input logic [TW-1:0]   trap_type,
  input logic [DW-1:0]   data0,
  input logic [DW-1:0]   data1,
  input logic [DW-1:0]   data2
);
  localparam int VW = $clog2(NVEC);

  // R2
  accept_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> (req && trap_type == TRAP_CODE));

  // R3
  accept_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> (data0[DW-1:VW] == TAG && data1 == '0 && data2 == '0));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |=> (!status[5] || $stable(data0)));

  // R6
  held_line_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && vec_lines[data0[VW-1:0]] && legacy_irq == '0) |=> status[5]);

  // R6
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[5] |-> (!req && trap_type == '0));

  // R7
  quiet_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[5] && vec_lines == '0 && legacy_irq == '0) |=> !status[5]);
endmodule

bind ivec_dispatch ivec_dispatch_chk #(
  .NVEC(NVEC), .NLEG(NLEG), .DW(DW), .TW(TW), .TAG(TAG), .TRAP_CODE(TRAP_CODE)
) u_chk (.*);

// File: tb/ivec_dispatch_tb.sv
module ivec_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] vec_lines = '0;
  logic [15:0] legacy_irq = '0;
  logic [7:0]  status;
  logic        req;
  logic [8:0]  trap_type;
  logic [15:0] data0, data1, data2;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivec_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .vec_lines(vec_lines), .legacy_irq(legacy_irq),
    .status(status), .req(req), .trap_type(trap_type),
    .data0(data0), .data1(data1), .data2(data2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_busy(input string tag, input logic [15:0] d0);
    chk({tag, " status"}, 32'(status), 32'h20);
    chk({tag, " req"}, 32'(req), 32'd1);
    chk({tag, " trap"}, 32'(trap_type), 32'h060);
    chk({tag, " data0"}, 32'(data0), 32'(d0));
    chk({tag, " data1/2"}, {data1, data2}, 32'd0);
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " status"}, 32'(status), 32'h0);
    chk({tag, " req"}, 32'(req), 32'd0);
    chk({tag, " trap"}, 32'(trap_type), 32'd0);
  endtask

  task automatic t_reset();
    chk_idle("R1 reset");
    chk("R1 data", {data0, data1}, 32'd0);
    chk("R1 data2", 32'(data2), 32'd0);
  endtask

  task automatic t_basic();
    vec_lines[5] = 1'b1; step();
    chk_busy("R2 R3 vec5", 16'h7C5);
    vec_lines[9] = 1'b1; step();
    chk_busy("R5 rise while busy", 16'h7C5);
    step();
    chk_busy("R5 rise while busy later", 16'h7C5);
    vec_lines[5] = 1'b0; step();
    chk_idle("R6 release");
    step();
    chk_idle("R7 level still high");
    vec_lines[9] = 1'b0; step();
    chk_idle("R7 low");
    vec_lines[9] = 1'b1; step();
    chk_busy("R7 re-rise", 16'h7C9);
    vec_lines = '0; step();
    chk_idle("R6 release 9");
  endtask

  task automatic t_prio();
    vec_lines[40] = 1'b1; vec_lines[17] = 1'b1; vec_lines[63] = 1'b1; step();
    chk_busy("R4 lowest wins", 16'h7D1);
    vec_lines[40] = 1'b0; step();
    chk_busy("R6 other line drop", 16'h7D1);
    vec_lines = '0; step();
    chk_idle("R6 all dropped");
    vec_lines[63] = 1'b1; step();
    chk_busy("R3 vec63", 16'h7FF);
    vec_lines = '0; step();
    vec_lines[0] = 1'b1; step();
    chk_busy("R3 vec0", 16'h7C0);
    vec_lines = '0; step();
    chk_idle("R6 vec0 release");
  endtask

  task automatic t_legacy();
    int irqs[5] = '{1, 4, 6, 7, 12};
    logic [15:0] vecs[5] = '{16'h29, 16'h2B, 16'h27, 16'h22, 16'h2A};
    for (int k = 0; k < 5; k++) begin
      legacy_irq[irqs[k]] = 1'b1; step();
      chk_busy($sformatf("R8 legacy %0d", irqs[k]), 16'h7C0 | vecs[k]);
      legacy_irq = '0; step();
      chk_idle($sformatf("R8 legacy %0d release", irqs[k]));
    end
  endtask

  task automatic t_legacy_ignored();
    legacy_irq = 16'hEF2D; step();
    chk_idle("R9 unmapped legacy");
    step();
    chk_idle("R9 unmapped legacy later");
    legacy_irq = '0; step();
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_prio();
        t_legacy();
        t_legacy_ignored();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++;
          bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule